// File: doc/BRIEF.md
# Protected Bit-Manipulation Register Unit

This unit is a small bank of 16-bit registers that software changes one bit or one byte field at a time. Every command runs as a read-modify-write of the whole word that holds the target. The word is read and the new value computed in the accept cycle, and the result is stored in the following write-back cycle. Some bits are flags that hardware may also raise or drop at any time through per-bit set and clear inputs.

Between the read and the write-back, hardware may change a flag. The write-back then replaces only the bits the command aims at. A hardware change to any other bit is kept. If software and hardware hit the same bit in the write-back cycle, the software value decides. Each command returns the old word and the old selected bit, plus a condition flag for the test forms.

Bit positions can be marked absent through a parameter mask. An absent position always reads 0 and ignores writes. A command aimed at a word outside the bank, or one carrying a reserved code, is rejected and changes nothing.

Top module: `prot_bit_bank`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly one cycle, the write-back, and a command offered while `busy` is high is ignored.
- R2: One cycle after acceptance `res_valid` is high for one cycle. `res_word` then holds the whole destination word as read, and `res_bit` holds its bit `cmd_bit` as read.
- R3: Single-bit codes write destination bit d, using source bit s taken from (`cmd_src_addr`, `cmd_src_bit`): 0 sets d, 1 clears d, 2 writes d AND s, 3 writes d OR s, 4 writes d XOR s, 5 writes s, 6 writes NOT s.
- R4: Code 7 updates the low byte and code 8 updates the high byte. Each bit of the chosen byte becomes (old AND NOT `cmd_mask`) OR (`cmd_data` AND `cmd_mask`), and the other byte is untouched.
- R5: Code 9 reports `res_hit` = bit and code 10 reports `res_hit` = NOT bit. Neither changes the bank.
- R6: Code 11 reports `res_hit` = bit and clears the bit only when the hit is 1. Code 12 reports `res_hit` = NOT bit and sets the bit only when the hit is 1.
- R7: A bit position outside `DEF_MASK` (by default bits 15..8 of word 7) always reads 0 and is never changed by any command.
- R8: A destination address of `NUM_WORDS` or more, or a code of 13..15, gives `res_rej` = 1 with `res_word` = 0, `res_bit` = 0 and `res_hit` = 0, and changes no word. A source address of `NUM_WORDS` or more reads as 0.
- R9: On bits marked in `PROT_MASK`, `hw_set` sets the bit and `hw_clr` clears it, at flat index word*16+bit, and set wins when both are high. By default the marked bits are bits 3..0 of word 0 and bits 15..8 of word 6. On unmarked bits both inputs have no effect.
- R10: The write-back changes only the targeted bits, so a hardware change made after the read survives.
- R11: When hardware changes a targeted bit in the write-back cycle, the software result sets the final value.
- R12: Synchronous reset clears every word and drives `busy` and `res_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | 4 | Destination word address |
| cmd_bit | input | 4 | Destination bit index |
| cmd_src_addr | input | 4 | Source word address |
| cmd_src_bit | input | 4 | Source bit index |
| cmd_mask | input | 8 | Field update mask |
| cmd_data | input | 8 | Field update data |
| hw_set | input | 128 | Per-bit hardware set, index word*16+bit |
| hw_clr | input | 128 | Per-bit hardware clear, index word*16+bit |
| busy | output | 1 | Write-back in progress |
| res_valid | output | 1 | Result strobe |
| res_word | output | 16 | Destination word as read |
| res_bit | output | 1 | Selected bit as read |
| res_hit | output | 1 | Test condition met |
| res_rej | output | 1 | Command rejected |

## Verification
The assertions on write-back take for granted that only the hardware inputs and the single write-back port ever change a word. They also assume that the hardware inputs are sampled on the same edge as the write. The stimulus therefore changes `hw_set`, `hw_clr` and command fields only at falling edges. It pulses the hardware inputs in the accept cycle and in the write-back cycle, so both the read-to-write window and the same-edge conflict occur. Commands held through the busy cycle test the blocking rule. Every expected value comes from a table filled in by hand from the requirements.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic [3:0] {
    OP_SET  = 4'd0,
    OP_CLR  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MOV  = 4'd5,
    OP_MOVN = 4'd6,
    OP_FLDL = 4'd7,
    OP_FLDH = 4'd8,
    OP_TSTS = 4'd9,
    OP_TSTC = 4'd10,
    OP_TCLR = 4'd11,
    OP_TSET = 4'd12
  } bitop_e;
endpackage

// File: rtl/pbr_bit_alu.sv
module pbr_bit_alu
  import pbr_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int FLD_W = DATA_W / 2
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] word,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              src_bit,
  input  logic [FLD_W-1:0]  mask,
  input  logic [FLD_W-1:0]  data,
  input  logic [DATA_W-1:0] def_word,
  output logic [DATA_W-1:0] targ,
  output logic [DATA_W-1:0] val,
  output logic              hit,
  output logic              bad_op
);
  logic [DATA_W-1:0] one_hot;
  logic              cur;
  logic [DATA_W-1:0] targ_raw;

  assign one_hot = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
  assign cur     = word[bit_idx];

  always_comb begin
    targ_raw = '0;
    val      = '0;
    hit      = 1'b0;
    bad_op   = 1'b0;
    case (bitop_e'(op))
      OP_SET:  begin targ_raw = one_hot; val = one_hot; end
      OP_CLR:  begin targ_raw = one_hot; end
      OP_AND:  begin targ_raw = one_hot; val = (cur & src_bit) ? one_hot : '0; end
      OP_OR:   begin targ_raw = one_hot; val = (cur | src_bit) ? one_hot : '0; end
      OP_XOR:  begin targ_raw = one_hot; val = (cur ^ src_bit) ? one_hot : '0; end
      OP_MOV:  begin targ_raw = one_hot; val = src_bit ? one_hot : '0; end
      OP_MOVN: begin targ_raw = one_hot; val = src_bit ? '0 : one_hot; end
      OP_FLDL: begin
        targ_raw = {{FLD_W{1'b0}}, mask};
        val      = {{FLD_W{1'b0}}, data};
      end
      OP_FLDH: begin
        targ_raw = {mask, {FLD_W{1'b0}}};
        val      = {data, {FLD_W{1'b0}}};
      end
      OP_TSTS: hit = cur;
      OP_TSTC: hit = ~cur;
      OP_TCLR: begin hit = cur;  targ_raw = cur ? one_hot : '0; end
      OP_TSET: begin hit = ~cur; targ_raw = cur ? '0 : one_hot; val = one_hot; end
      default: bad_op = 1'b1;
    endcase
  end

  assign targ = targ_raw & def_word;
endmodule

// File: rtl/pbr_word_cell.sv
module pbr_word_cell #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] DEF  = '1,
  parameter logic [WIDTH-1:0] PROT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hw_set,
  input  logic [WIDTH-1:0] hw_clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_targ,
  input  logic [WIDTH-1:0] wr_val,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] HW_BITS = DEF & PROT;

  logic [WIDTH-1:0] set_m, clr_m, after_hw, nxt;

  assign set_m    = hw_set & HW_BITS;
  assign clr_m    = hw_clr & HW_BITS & ~set_m;
  assign after_hw = (q | set_m) & ~clr_m;

  always_comb begin
    nxt = after_hw;
    if (wr_en) nxt = (after_hw & ~wr_targ) | (wr_val & wr_targ);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt & DEF;
  end
endmodule

// File: rtl/prot_bit_bank.sv
module prot_bit_bank
  import pbr_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter logic [NUM_WORDS*DATA_W-1:0] DEF_MASK  = {16'h00FF, {112{1'b1}}},
  parameter logic [NUM_WORDS*DATA_W-1:0] PROT_MASK = {16'h0000, 16'hFF00, 80'h0, 16'h000F},
  localparam int BIT_W = $clog2(DATA_W),
  localparam int FLD_W = DATA_W / 2,
  localparam int IDX_W = $clog2(NUM_WORDS),
  localparam int FLAT_W = NUM_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BIT_W-1:0]  cmd_bit,
  input  logic [ADDR_W-1:0] cmd_src_addr,
  input  logic [BIT_W-1:0]  cmd_src_bit,
  input  logic [FLD_W-1:0]  cmd_mask,
  input  logic [FLD_W-1:0]  cmd_data,
  input  logic [FLAT_W-1:0] hw_set,
  input  logic [FLAT_W-1:0] hw_clr,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_word,
  output logic              res_bit,
  output logic              res_hit,
  output logic              res_rej
);
  logic [DATA_W-1:0] bank [NUM_WORDS];
  logic [FLAT_W-1:0] bank_flat;

  logic              accept, dst_ok, src_ok;
  logic [DATA_W-1:0] rd_word, def_word, src_word;
  logic              src_bit_v;
  logic [DATA_W-1:0] alu_targ, alu_val;
  logic              alu_hit, alu_bad, reject;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_targ, wr_val;

  assign accept = cmd_valid & ~busy;
  assign dst_ok = cmd_addr < ADDR_W'(NUM_WORDS);
  assign src_ok = cmd_src_addr < ADDR_W'(NUM_WORDS);

  assign rd_word   = dst_ok ? bank[cmd_addr[IDX_W-1:0]] : '0;
  assign def_word  = dst_ok ? DEF_MASK[cmd_addr[IDX_W-1:0]*DATA_W +: DATA_W] : '0;
  assign src_word  = src_ok ? bank[cmd_src_addr[IDX_W-1:0]] : '0;
  assign src_bit_v = src_word[cmd_src_bit];

  pbr_bit_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (cmd_op),
    .word    (rd_word),
    .bit_idx (cmd_bit),
    .src_bit (src_bit_v),
    .mask    (cmd_mask),
    .data    (cmd_data),
    .def_word(def_word),
    .targ    (alu_targ),
    .val     (alu_val),
    .hit     (alu_hit),
    .bad_op  (alu_bad)
  );

  assign reject = ~dst_ok | alu_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_word  <= '0;
      res_bit   <= 1'b0;
      res_hit   <= 1'b0;
      res_rej   <= 1'b0;
      wr_idx    <= '0;
      wr_targ   <= '0;
      wr_val    <= '0;
    end else begin
      busy      <= accept;
      res_valid <= accept;
      if (accept) begin
        res_word <= reject ? '0 : rd_word;
        res_bit  <= reject ? 1'b0 : rd_word[cmd_bit];
        res_hit  <= reject ? 1'b0 : alu_hit;
        res_rej  <= reject;
        wr_idx   <= cmd_addr[IDX_W-1:0];
        wr_targ  <= reject ? '0 : alu_targ;
        wr_val   <= alu_val;
      end
    end
  end

  assign wr_en = busy & ~res_rej;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    pbr_word_cell #(
      .WIDTH(DATA_W),
      .DEF  (DEF_MASK[g*DATA_W +: DATA_W]),
      .PROT (PROT_MASK[g*DATA_W +: DATA_W])
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .hw_set (hw_set[g*DATA_W +: DATA_W]),
      .hw_clr (hw_clr[g*DATA_W +: DATA_W]),
      .wr_en  (wr_en && (wr_idx == IDX_W'(g))),
      .wr_targ(wr_targ),
      .wr_val (wr_val),
      .q      (bank[g])
    );
    assign bank_flat[g*DATA_W +: DATA_W] = bank[g];
  end
endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
  parameter int NUM_WORDS = 8,
  parameter int DATA_W    = 16,
  parameter logic [NUM_WORDS*DATA_W-1:0] DEF_MASK  = '1,
  parameter logic [NUM_WORDS*DATA_W-1:0] PROT_MASK = '0,
  localparam int IDX_W  = $clog2(NUM_WORDS),
  localparam int FLAT_W = NUM_WORDS * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              res_valid,
  input logic              res_rej,
  input logic [FLAT_W-1:0] hw_set,
  input logic [FLAT_W-1:0] hw_clr,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_targ,
  input logic [DATA_W-1:0] wr_val,
  input logic [FLAT_W-1:0] bank_flat
);
  localparam logic [FLAT_W-1:0] HWB = DEF_MASK & PROT_MASK;

  logic [FLAT_W-1:0] targ_flat, val_flat;

  always_comb begin
    targ_flat = '0;
    val_flat  = '0;
    if (wr_en) begin
      targ_flat[wr_idx*DATA_W +: DATA_W] = wr_targ;
      val_flat[wr_idx*DATA_W +: DATA_W]  = wr_val;
    end
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);
  assert_busy_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
  assert_result_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(cmd_valid && !busy));
  assert_undefined_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bank_flat & ~DEF_MASK) == '0);
  assert_reject_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_rej) |-> !wr_en);
  assert_hw_set_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (bank_flat & $past(hw_set & HWB & ~targ_flat)) == $past(hw_set & HWB & ~targ_flat));
  assert_hw_clr_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (bank_flat & $past(hw_clr & ~hw_set & HWB & ~targ_flat)) == '0);
  assert_untargeted_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (bank_flat & ~HWB & ~$past(targ_flat)) == ($past(bank_flat) & ~HWB & ~$past(targ_flat)));
  assert_software_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (bank_flat & $past(targ_flat)) == ($past(val_flat) & $past(targ_flat)));
endmodule

bind prot_bit_bank pbr_checker #(
  .NUM_WORDS(NUM_WORDS),
  .DATA_W   (DATA_W),
  .DEF_MASK (DEF_MASK),
  .PROT_MASK(PROT_MASK)
) u_pbr_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .busy     (busy),
  .res_valid(res_valid),
  .res_rej  (res_rej),
  .hw_set   (hw_set),
  .hw_clr   (hw_clr),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_targ  (wr_targ),
  .wr_val   (wr_val),
  .bank_flat(bank_flat)
);

// File: tb/test_prot_bit_bank.sv
module test_prot_bit_bank;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [3:0]   cmd_op = '0, cmd_addr = '0, cmd_bit = '0, cmd_src_addr = '0, cmd_src_bit = '0;
  logic [7:0]   cmd_mask = '0, cmd_data = '0;
  logic [127:0] hw_set = '0, hw_clr = '0;
  logic         busy, res_valid, res_bit, res_hit, res_rej;
  logic [15:0]  res_word;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic done = 1'b0;

  logic        c_valid, c_bit, c_hit, c_rej;
  logic [15:0] c_word;

  always #10 clk = ~clk;

  prot_bit_bank i_prot_bit_bank (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_bit(cmd_bit), .cmd_src_addr(cmd_src_addr),
    .cmd_src_bit(cmd_src_bit), .cmd_mask(cmd_mask), .cmd_data(cmd_data),
    .hw_set(hw_set), .hw_clr(hw_clr), .busy(busy), .res_valid(res_valid),
    .res_word(res_word), .res_bit(res_bit), .res_hit(res_hit), .res_rej(res_rej)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, a, b, sa, sb, input logic [7:0] m, d);
    cmd_op = op; cmd_addr = a; cmd_bit = b; cmd_src_addr = sa; cmd_src_bit = sb;
    cmd_mask = m; cmd_data = d;
  endtask

  task automatic do_cmd(input logic [3:0] op, a, b, sa, sb, input logic [7:0] m, d);
    @(negedge clk);
    drive(op, a, b, sa, sb, m, d);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    c_valid = res_valid; c_word = res_word; c_bit = res_bit; c_hit = res_hit; c_rej = res_rej;
    @(negedge clk);
  endtask

  // fields: op,addr,bit,saddr,sbit,mask,data | exp bit,hit,rej,word
  localparam int NV = 25;
  localparam logic [54:0] VEC [NV] = '{
    {4'd0, 4'd1, 4'd3, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd9, 4'd1, 4'd3, 4'd0, 4'd0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0008},
    {4'd4, 4'd1, 4'd3, 4'd1, 4'd3, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0008},
    {4'd7, 4'd2, 4'd0, 4'd0, 4'd0, 8'hF0, 8'hA5, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd8, 4'd2, 4'd0, 4'd0, 4'd0, 8'h0F, 8'h3C, 1'b0, 1'b0, 1'b0, 16'h00A0},
    {4'd6, 4'd3, 4'd0, 4'd2, 4'd4, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd3, 4'd3, 4'd15, 4'd2, 4'd11, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0001},
    {4'd2, 4'd3, 4'd0, 4'd1, 4'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'h8001},
    {4'd11, 4'd3, 4'd15, 4'd0, 4'd0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 16'h8000},
    {4'd11, 4'd3, 4'd15, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd12, 4'd3, 4'd2, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0000},
    {4'd10, 4'd3, 4'd2, 4'd0, 4'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0004},
    {4'd5, 4'd4, 4'd7, 4'd3, 4'd2, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd1, 4'd4, 4'd7, 4'd0, 4'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0080},
    {4'd0, 4'd9, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0000},
    {4'd0, 4'd7, 4'd12, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd9, 4'd7, 4'd12, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd8, 4'd7, 4'd0, 4'd0, 4'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd7, 4'd7, 4'd0, 4'd0, 4'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd9, 4'd7, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 16'h00FF},
    {4'd13, 4'd4, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0000},
    {4'd9, 4'd4, 4'd7, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd0, 4'd4, 4'd1, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'd5, 4'd4, 4'd1, 4'd12, 4'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0002},
    {4'd9, 4'd4, 4'd1, 4'd0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000}
  };

  function automatic string tag_of(input logic [3:0] op, input logic [3:0] a, input logic [3:0] sa);
    if (a >= 4'd8 || op >= 4'd13 || sa >= 4'd8) return "R8";
    if (a == 4'd7) return "R7";
    if (op <= 4'd6) return "R3";
    if (op <= 4'd8) return "R4";
    if (op <= 4'd10) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R12 busy after reset", {31'd0, busy}, 32'd0);
    check("R12 res_valid after reset", {31'd0, res_valid}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      string t;
      v = VEC[i];
      t = tag_of(v[54:51], v[50:47], v[42:39]);
      do_cmd(v[54:51], v[50:47], v[46:43], v[42:39], v[38:35], v[34:27], v[26:19]);
      check($sformatf("%s/R2 vector %0d {valid,bit,hit,rej,word}", t, i),
            {12'd0, c_valid, c_bit, c_hit, c_rej, c_word},
            {12'd0, 1'b1, v[18], v[17], v[16], v[15:0]});
    end

    // R1: command held through the busy cycle is not taken again
    @(negedge clk);
    drive(4'd0, 4'd5, 4'd1, 4'd0, 4'd0, 8'h00, 8'h00);
    cmd_valid = 1'b1;
    @(negedge clk);
    check("R1 busy in write-back", {31'd0, busy}, 32'd1);
    drive(4'd0, 4'd5, 4'd2, 4'd0, 4'd0, 8'h00, 8'h00);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 busy drops after one cycle", {31'd0, busy}, 32'd0);
    do_cmd(4'd9, 4'd5, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00);
    check("R1 blocked command left no trace", {16'd0, c_word}, 32'h0002);

    // R10/R11/R9: hardware activity around a read-modify-write of word 0
    @(negedge clk);
    drive(4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00);
    cmd_valid = 1'b1;
    hw_set[1] = 1'b1;                     // lands between read and write-back
    @(negedge clk);
    cmd_valid = 1'b0;
    hw_set = '0;
    hw_set[2] = 1'b1; hw_set[3] = 1'b1; hw_clr[3] = 1'b1;   // set beats clear
    hw_clr[0] = 1'b1;                     // conflicts with software target
    hw_set[16] = 1'b1;                    // word 1 bit 0, unprotected
    @(negedge clk);
    hw_set = '0; hw_clr = '0;
    do_cmd(4'd9, 4'd0, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00);
    check("R10/R11/R9 word0 after hw activity", {16'd0, c_word}, 32'h000F);
    do_cmd(4'd9, 4'd1, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00);
    check("R9 unprotected bit ignores hw_set", {16'd0, c_word}, 32'h0000);

    @(negedge clk);
    hw_clr[1] = 1'b1; hw_clr[20] = 1'b1;
    hw_set[100] = 1'b1;                   // word 6 bit 4, unprotected
    hw_set[110] = 1'b1;                   // word 6 bit 14, protected
    @(negedge clk);
    hw_set = '0; hw_clr = '0;
    do_cmd(4'd9, 4'd0, 4'd1, 4'd0, 4'd0, 8'h00, 8'h00);
    check("R9 hw_clr on protected bit", {15'd0, c_bit, c_word}, 32'h0000_000D);
    do_cmd(4'd9, 4'd6, 4'd14, 4'd0, 4'd0, 8'h00, 8'h00);
    check("R9 word6 protection field", {15'd0, c_bit, c_word}, 32'h0001_4000);

    // R12: reset mid-run clears the bank
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    do_cmd(4'd9, 4'd0, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00);
    check("R12 word0 cleared by reset", {16'd0, c_word}, 32'h0000);
    do_cmd(4'd9, 4'd7, 4'd0, 4'd0, 4'd0, 8'h00, 8'h00);
    check("R12 word7 cleared by reset", {16'd0, c_word}, 32'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule